// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Detector and Acceptance Gate

This block turns one asynchronous non-maskable interrupt pin into a pending request and decides when the CPU may take it. The pin is first resynchronised. The block then looks for one edge polarity, chosen by a select input: falling edges when the select is 0, rising edges when it is 1. A detected edge sets a pending flag. That flag stays set until the exception entry logic pulses a clear input. While it is pending, the request reports priority level 16, which is above every maskable source.

Changing the edge select briefly disturbs the edge comparator. For that reason detection is blanked for a fixed number of bus clocks after every change of the select. An edge that falls inside this window is thrown away, not saved for later. Acceptance is normally held off while the CPU block bit is 1. Two cases override this: sleep mode, and an override configuration bit. On acceptance the block emits a one-cycle accept pulse. When mask update is enabled, it also emits a request to force the CPU interrupt mask to level 15.

Top module: `nmi_accept_unit`

## Requirements
- R1: After reset, pending, accept_pulse and mask_force are 0 and req_level is 0.
- R2: With edge_sel = 0, a high-to-low change on nmi_pin sets pending on the third rising clock edge after the change, because of two synchronizer stages and one detection register. A low-to-high change does not set pending.
- R3: With edge_sel = 1, a low-to-high change on nmi_pin sets pending with the same latency, and a high-to-low change does not.
- R4: A change of edge_sel starts a blanking window of BLANK_CYCLES (default 6) further clock edges. An edge whose detection would register within that window is discarded, and pending stays 0 afterwards. An edge detected on the first clock edge after the window sets pending.
- R5: pending stays set until clr_pending is pulsed. A new edge detected in the same cycle as clr_pending leaves pending set, as a fresh request.
- R6: clr_pending with no new edge clears pending on the next clock edge.
- R7: accept_pulse is 1 for exactly one cycle per pending request, in the first cycle in which the request is acceptable.
- R8: While cpu_block is 1, with sleep_mode and accept_when_blocked both 0, a pending request is not accepted and stays pending. It is accepted once cpu_block returns to 0.
- R9: While sleep_mode is 1, a pending request is accepted even when cpu_block is 1.
- R10: While accept_when_blocked is 1, a pending request is accepted even when cpu_block is 1.
- R11: mask_force is 1 exactly when accept_pulse is 1 and mask_update_en is 1. When it is 1, mask_value is 15. With mask_update_en = 0, an acceptance gives mask_force = 0.
- R12: req_level is 16 while pending is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin |
| edge_sel | input | 1 | 0 = detect falling edge, 1 = detect rising edge |
| cpu_block | input | 1 | CPU block bit; 1 holds acceptance off |
| sleep_mode | input | 1 | CPU is asleep; acceptance ignores the block bit |
| accept_when_blocked | input | 1 | Configuration: accept even while blocked |
| mask_update_en | input | 1 | Configuration: force mask level on acceptance |
| clr_pending | input | 1 | Clear pulse from exception entry logic |
| pending | output | 1 | Request is pending |
| accept_pulse | output | 1 | One-cycle acceptance strobe |
| mask_force | output | 1 | Request to overwrite the CPU mask level |
| mask_value | output | MASK_W | Mask level to write (15) |
| req_level | output | LEVEL_W | Priority of the pending request (16 or 0) |

## Verification
The bench places edges on both sides of the blanking boundary: one detected on the last blanked clock edge and one on the first clock edge after it. A window that is one cycle short or one cycle long fails one of the two. It also waits long after a discarded edge, which catches a design that defers the edge instead of dropping it. A clear and a new edge are made to land in the same cycle; a design that gives the clear priority loses the new request. The block bit is set with each of the two overrides in turn, and the bench checks that the accept strobe is not repeated while a request stays pending.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int NMI_LEVEL      = 16;
  localparam int NMI_MASK_LEVEL = 15;

  // Edge of the chosen polarity between previous and current sample
  function automatic logic edge_hit(input logic rise_sel, input logic cur, input logic prev);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // A new edge wins over a clear arriving in the same cycle
  function automatic logic pend_next(input logic pend, input logic clr, input logic det);
    return det | (pend & ~clr);
  endfunction

  // Acceptable when not blocked, or when an override applies
  function automatic logic may_accept(input logic blocked, input logic asleep, input logic ovr);
    return ~blocked | asleep | ovr;
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nmi_edge_gate.sv
module nmi_edge_gate
  import nmi_pkg::*;
#(
  parameter int BLANK_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic rise_sel,
  output logic det,
  output logic blank_busy
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);

  logic          prev;
  logic          sel_q;
  logic [CW-1:0] blank_cnt;
  logic          sel_change;
  logic          raw_edge;

  assign sel_change = rise_sel ^ sel_q;
  assign raw_edge   = edge_hit(rise_sel, pin_s, prev);
  assign blank_busy = sel_change | (blank_cnt != '0);
  assign det        = raw_edge & ~blank_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      sel_q     <= 1'b0;
      blank_cnt <= '0;
    end else begin
      prev  <= pin_s;
      sel_q <= rise_sel;
      if (sel_change)
        blank_cnt <= CW'(BLANK_CYCLES);
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end

  // R4: every change of the select reloads the full window
  a_r4_blank_reload: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (blank_cnt == CW'(BLANK_CYCLES)));

  // R4: the window only counts downward while the select is steady
  a_r4_blank_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_change && blank_cnt != '0) |=> (blank_cnt == $past(blank_cnt) - 1'b1));
endmodule

// File: rtl/nmi_accept_ctrl.sv
module nmi_accept_ctrl
  import nmi_pkg::*;
#(
  parameter int MASK_W  = 4,
  parameter int LEVEL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det,
  input  logic               clr,
  input  logic               cpu_block,
  input  logic               sleep_mode,
  input  logic               accept_when_blocked,
  input  logic               mask_update_en,
  output logic               pending,
  output logic               accept_pulse,
  output logic               mask_force,
  output logic [MASK_W-1:0]  mask_value,
  output logic [LEVEL_W-1:0] req_level
);
  logic taken;
  logic ok_now;

  assign ok_now       = may_accept(cpu_block, sleep_mode, accept_when_blocked);
  assign accept_pulse = pending & ~taken & ok_now;
  assign mask_force   = accept_pulse & mask_update_en;
  assign mask_value   = MASK_W'(NMI_MASK_LEVEL);
  assign req_level    = pending ? LEVEL_W'(NMI_LEVEL) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      taken   <= 1'b0;
    end else begin
      pending <= pend_next(pending, clr, det);
      taken   <= clr ? 1'b0 : (taken | accept_pulse);
    end
  end

  // R5: a detected edge always leaves the request pending
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> pending);

  // R6: a clear without a new edge drops the request
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !det) |=> !pending);

  // R7: no back-to-back acceptance of one request
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_pulse && !clr) |=> !accept_pulse);

  // R8: acceptance while blocked needs an override
  a_r8_block_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_pulse && cpu_block) |-> (sleep_mode || accept_when_blocked));

  // R11: mask force only with an acceptance and the enable
  a_r11_mask_force: assert property (@(posedge clk) disable iff (!rst_n)
    mask_force |-> (accept_pulse && mask_update_en && mask_value == MASK_W'(15)));
endmodule

// File: rtl/nmi_accept_unit.sv
module nmi_accept_unit #(
  parameter int BLANK_CYCLES = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int MASK_W       = 4,
  parameter int LEVEL_W      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_pin,
  input  logic               edge_sel,
  input  logic               cpu_block,
  input  logic               sleep_mode,
  input  logic               accept_when_blocked,
  input  logic               mask_update_en,
  input  logic               clr_pending,
  output logic               pending,
  output logic               accept_pulse,
  output logic               mask_force,
  output logic [MASK_W-1:0]  mask_value,
  output logic [LEVEL_W-1:0] req_level
);
  logic pin_s;
  logic edge_det;
  logic blank_busy;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (nmi_pin),
    .q   (pin_s)
  );

  nmi_edge_gate #(.BLANK_CYCLES(BLANK_CYCLES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s      (pin_s),
    .rise_sel   (edge_sel),
    .det        (edge_det),
    .blank_busy (blank_busy)
  );

  nmi_accept_ctrl #(.MASK_W(MASK_W), .LEVEL_W(LEVEL_W)) u_ctrl (
    .clk                 (clk),
    .rst_n               (rst_n),
    .det                 (edge_det),
    .clr                 (clr_pending),
    .cpu_block           (cpu_block),
    .sleep_mode          (sleep_mode),
    .accept_when_blocked (accept_when_blocked),
    .mask_update_en      (mask_update_en),
    .pending             (pending),
    .accept_pulse        (accept_pulse),
    .mask_force          (mask_force),
    .mask_value          (mask_value),
    .req_level           (req_level)
  );

  // R4: an edge is never taken while the window is open
  a_r4_no_det_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_busy && !pending && !clr_pending) |=> !pending);

  // R12: a pending request reports the top priority level
  a_r12_level: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (req_level == LEVEL_W'(16)));
endmodule

// File: tb/test_nmi_accept_unit.sv
module test_nmi_accept_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b1;
  logic edge_sel = 1'b0;
  logic cpu_block = 1'b0;
  logic sleep_mode = 1'b0;
  logic accept_when_blocked = 1'b0;
  logic mask_update_en = 1'b1;
  logic clr_pending = 1'b0;
  logic pending, accept_pulse, mask_force;
  logic [3:0] mask_value;
  logic [4:0] req_level;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_accept_unit i_nmi_accept_unit (
    .clk (clk), .rst_n (rst_n), .nmi_pin (nmi_pin), .edge_sel (edge_sel),
    .cpu_block (cpu_block), .sleep_mode (sleep_mode),
    .accept_when_blocked (accept_when_blocked), .mask_update_en (mask_update_en),
    .clr_pending (clr_pending), .pending (pending), .accept_pulse (accept_pulse),
    .mask_force (mask_force), .mask_value (mask_value), .req_level (req_level)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // advance n negedges, then settle combinational outputs
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_req();
    clr_pending = 1'b1;
    step(1);
    clr_pending = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    check(pending, 0, "R1 pending in reset");
    check(req_level, 0, "R1 level in reset");
    step(2);
    rst_n = 1'b1;
    step(4);
    check(pending, 0, "R1 pending after release");
    check(accept_pulse, 0, "R1 accept after release");
    check(mask_force, 0, "R1 mask_force after release");
  endtask

  task automatic t_fall();
    nmi_pin = 1'b0;
    step(2);
    check(pending, 0, "R2 not yet pending at 2 edges");
    step(1);
    check(pending, 1, "R2 falling edge pending");
    check(accept_pulse, 1, "R7 accept on first acceptable cycle");
    check(req_level, 16, "R12 level while pending");
    check(mask_force, 1, "R11 mask force with enable");
    check(mask_value, 15, "R11 mask value");
    step(1);
    check(accept_pulse, 0, "R7 pulse lasts one cycle");
    check(pending, 1, "R5 still pending");
    clear_req();
    check(pending, 0, "R6 cleared");
    check(req_level, 0, "R12 level after clear");
    nmi_pin = 1'b1;
    step(4);
    check(pending, 0, "R2 rising ignored in falling mode");
  endtask

  task automatic t_mask_off();
    mask_update_en = 1'b0;
    nmi_pin = 1'b0;
    step(3);
    check(accept_pulse, 1, "R11 accept without enable");
    check(mask_force, 0, "R11 no mask force without enable");
    clear_req();
    nmi_pin = 1'b1;
    mask_update_en = 1'b1;
    step(3);
  endtask

  task automatic t_block();
    cpu_block = 1'b1;
    nmi_pin = 1'b0;
    step(3);
    check(pending, 1, "R8 pending while blocked");
    check(accept_pulse, 0, "R8 held off while blocked");
    step(2);
    check(accept_pulse, 0, "R8 still held off");
    check(pending, 1, "R5 pending held across cycles");
    cpu_block = 1'b0;
    #1;
    check(accept_pulse, 1, "R8 accepted after unblock");
    step(1);
    check(accept_pulse, 0, "R7 single pulse after unblock");
    clear_req();
    nmi_pin = 1'b1;
    step(3);
  endtask

  task automatic t_override(input bit use_sleep);
    cpu_block = 1'b1;
    sleep_mode = use_sleep;
    accept_when_blocked = !use_sleep;
    nmi_pin = 1'b0;
    step(3);
    if (use_sleep) check(accept_pulse, 1, "R9 sleep accepts while blocked");
    else           check(accept_pulse, 1, "R10 override accepts while blocked");
    clear_req();
    cpu_block = 1'b0;
    sleep_mode = 1'b0;
    accept_when_blocked = 1'b0;
    nmi_pin = 1'b1;
    step(3);
  endtask

  task automatic t_collide();
    nmi_pin = 1'b0;
    step(3);
    check(pending, 1, "R5 first request");
    step(1);
    nmi_pin = 1'b1;
    step(3);
    nmi_pin = 1'b0;
    step(2);
    clr_pending = 1'b1;
    step(1);
    clr_pending = 1'b0;
    #1;
    check(pending, 1, "R5 edge with clear keeps pending");
    check(accept_pulse, 1, "R5 fresh request accepted");
    clear_req();
    nmi_pin = 1'b1;
    step(3);
  endtask

  task automatic t_blank();
    // switch to rising mode; falling pin edge inside window is dropped anyway
    edge_sel = 1'b1;
    nmi_pin = 1'b0;
    step(10);
    check(pending, 0, "R4 edge in window dropped");
    nmi_pin = 1'b1;
    step(3);
    check(pending, 1, "R3 rising edge pending");
    clear_req();
    nmi_pin = 1'b0;
    step(4);
    check(pending, 0, "R3 falling ignored in rising mode");
    nmi_pin = 1'b1;
    step(4);
    clear_req();
    // last blanked edge: switch to falling, pin falls four edges later
    edge_sel = 1'b0;
    step(4);
    nmi_pin = 1'b0;
    step(3);
    check(pending, 0, "R4 edge on last blanked cycle dropped");
    step(6);
    check(pending, 0, "R4 dropped edge not deferred");
    // first open edge: restart window, pin falls five edges later
    nmi_pin = 1'b1;
    edge_sel = 1'b1;
    step(10);
    clear_req();
    edge_sel = 1'b0;
    step(5);
    nmi_pin = 1'b0;
    step(3);
    check(pending, 1, "R4 edge right after window taken");
    clear_req();
  endtask

  initial begin
    t_reset();
    t_fall();
    t_mask_off();
    t_block();
    t_override(1'b1);
    t_override(1'b0);
    t_collide();
    t_blank();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule